// File: doc/BRIEF.md
# Host Bus Register-Access Front End

This block sits between an asynchronous CPU bus and the eight-location register file of a serial controller. It brings the bus signals into the system clock domain, decides whether a bus cycle addresses this device, and turns each qualified read or write into one-cycle enables for the addressed location. Other logic holds the register contents and sees only these enables, the write data and a read-data vector that the front end selects from.

The device responds only to one combination of its three chip selects: the first two high and the third low. Register select and chip selects can arrive in two ways. While the address strobe is low, they pass straight through to the decode. When the strobe rises, the values present at that edge are frozen and stay frozen for as long as the strobe stays high. A read and a write can each be started by either of two strobes of opposite polarity. During a qualified read the front end drives the selected register onto its data output with an output enable. At all other times it holds a transceiver-disable output high.

All bus inputs pass through a synchronizer of `SYNC_STAGES` flops and then one output register. An input change therefore reaches the outputs `SYNC_STAGES + 1` clock edges after it is first sampled.

Top module: `hbus_front`

## Requirements
- R1: A cycle is acted on only when `cs_a` = 1, `cs_b` = 1 and `cs_c_n` = 0. If any one of the three is inactive, a strobe produces no write enable, no read pulse and no output enable.
- R2: While `astb_n` is 0, the decode uses the current `reg_addr` and chip selects, so a change of address while the strobe is low is followed.
- R3: When `astb_n` rises, the `reg_addr` and chip-select values sampled at that edge are held and used for as long as `astb_n` stays 1. Later changes on those inputs have no effect until the strobe goes low again.
- R4: A write is triggered by `wr_p` = 1 or `wr_n` = 0 while selected. It sets bit `reg_addr` of `wr_en` (bit k means location k) and presents `bus_din` on `wr_data`, `SYNC_STAGES + 1` clock edges after the strobe is sampled.
- R5: Each assertion of a qualified write strobe gives a `wr_en` pulse exactly one clock long, however long the strobe is held.
- R6: A read is triggered by `rd_p` = 1 or `rd_n` = 0 while selected. For as long as the read lasts, `bus_oe` = 1 and `bus_dout` equals bits [k*8 +: 8] of `reg_rdata`, where k is the effective address. Outside a read, `bus_oe` = 0 and `bus_dout` = 0.
- R7: `xcvr_dis` is 1 whenever no qualified read is in progress and 0 during one.
- R8: Each qualified read gives a one-clock pulse on bit k of `rd_pulse` at the same edge at which `bus_oe` rises.
- R9: After reset, `wr_en`, `rd_pulse`, `bus_oe`, `bus_dout` and `wr_data` are 0 and `xcvr_dis` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | AW | Register select |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| astb_n | input | 1 | Address strobe: 0 passes through, rising edge freezes |
| rd_p | input | 1 | Read strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_p | input | 1 | Write strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| bus_din | input | DW | Write data from the CPU bus |
| reg_rdata | input | NREG*DW | Contents of all locations, location k at [k*DW +: DW] |
| wr_en | output | NREG | One-hot single-cycle write enable |
| wr_data | output | DW | Data captured with the write enable |
| rd_pulse | output | NREG | One-hot single-cycle read pulse |
| bus_dout | output | DW | Read data, zero when not driving |
| bus_oe | output | 1 | Read data output enable |
| xcvr_dis | output | 1 | High when no read of the device is in progress |

## Verification
The bench builds the block with its defaults: AW = 3 (eight locations), DW = 8 and SYNC_STAGES = 2. Every location can therefore be hit, and every response is expected exactly three clock edges after the input change. With a two-stage synchronizer, the bench can change the address a whole clock after a strobe rises, which separates the frozen value from the live one and makes the hold and pass-through cases distinguishable at the outputs. A strobe held for several clocks shows that the write and read pulses stay single, and each chip select is deactivated on its own.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef struct packed {
    logic cs_a;
    logic cs_b;
    logic cs_c_n;
    logic astb_n;
    logic rd_p;
    logic rd_n;
    logic wr_p;
    logic wr_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Deselected, transparent, no strobe active.
  localparam ctl_t CTL_IDLE = '{cs_a: 1'b0, cs_b: 1'b0, cs_c_n: 1'b1,
                                astb_n: 1'b0, rd_p: 1'b0, rd_n: 1'b1,
                                wr_p: 1'b0, wr_n: 1'b1};

  function automatic logic chip_selected(input logic a, input logic b,
                                         input logic c_n);
    return a & b & ~c_n;
  endfunction

  function automatic logic strobe_on(input logic hi, input logic lo_n);
    return hi | ~lo_n;
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          astb_n,
  input  logic [AW-1:0] addr_live,
  input  logic          sel_live,
  output logic [AW-1:0] addr_eff,
  output logic          sel_eff
);

  logic [AW-1:0] addr_hold;
  logic          sel_hold;

  // Keep tracking while the strobe is low; the last low sample is the frozen value.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hold <= '0;
      sel_hold  <= 1'b0;
    end else if (!astb_n) begin
      addr_hold <= addr_live;
      sel_hold  <= sel_live;
    end
  end

  assign addr_eff = astb_n ? addr_hold : addr_live;
  assign sel_eff  = astb_n ? sel_hold  : sel_live;

endmodule

// File: rtl/hbus_cycle_qual.sv
module hbus_cycle_qual (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_lvl,
  output logic rd_rise,
  output logic wr_rise
);

  logic rd_prev;
  logic wr_prev;
  logic wr_lvl;

  assign rd_lvl = sel & rd_req;
  assign wr_lvl = sel & wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_lvl;
      wr_prev <= wr_lvl;
    end
  end

  assign rd_rise = rd_lvl & ~rd_prev;
  assign wr_rise = wr_lvl & ~wr_prev;

endmodule

// File: rtl/hbus_front.sv
module hbus_front
  import hbus_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NREG = 1 << AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    reg_addr,
  input  logic             cs_a,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             astb_n,
  input  logic             rd_p,
  input  logic             rd_n,
  input  logic             wr_p,
  input  logic             wr_n,
  input  logic [DW-1:0]    bus_din,
  input  logic [NREG*DW-1:0] reg_rdata,
  output logic [NREG-1:0]  wr_en,
  output logic [DW-1:0]    wr_data,
  output logic [NREG-1:0]  rd_pulse,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_oe,
  output logic             xcvr_dis
);

  ctl_t          ctl_raw, ctl_s;
  logic [AW-1:0] addr_s, addr_eff;
  logic [DW-1:0] din_s;
  logic          sel_eff;
  logic          rd_lvl, rd_rise, wr_rise;
  logic [NREG-1:0] dec;
  logic [DW-1:0] rsel;

  assign ctl_raw = '{cs_a: cs_a, cs_b: cs_b, cs_c_n: cs_c_n, astb_n: astb_n,
                     rd_p: rd_p, rd_n: rd_n, wr_p: wr_p, wr_n: wr_n};

  hbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) ctl_sync_i (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  hbus_sync #(.W(AW), .STAGES(SYNC_STAGES)) addr_sync_i (
    .clk(clk), .rst(rst), .d(reg_addr), .q(addr_s)
  );

  hbus_sync #(.W(DW), .STAGES(SYNC_STAGES)) din_sync_i (
    .clk(clk), .rst(rst), .d(bus_din), .q(din_s)
  );

  hbus_addr_latch #(.AW(AW)) latch_i (
    .clk      (clk),
    .rst      (rst),
    .astb_n   (ctl_s.astb_n),
    .addr_live(addr_s),
    .sel_live (chip_selected(ctl_s.cs_a, ctl_s.cs_b, ctl_s.cs_c_n)),
    .addr_eff (addr_eff),
    .sel_eff  (sel_eff)
  );

  hbus_cycle_qual qual_i (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel_eff),
    .rd_req (strobe_on(ctl_s.rd_p, ctl_s.rd_n)),
    .wr_req (strobe_on(ctl_s.wr_p, ctl_s.wr_n)),
    .rd_lvl (rd_lvl),
    .rd_rise(rd_rise),
    .wr_rise(wr_rise)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign dec[g] = (addr_eff == AW'(g));
  end

  assign rsel = reg_rdata[addr_eff*DW +: DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= '0;
      wr_data  <= '0;
      rd_pulse <= '0;
      bus_dout <= '0;
      bus_oe   <= 1'b0;
      xcvr_dis <= 1'b1;
    end else begin
      wr_en    <= wr_rise ? dec : '0;
      rd_pulse <= rd_rise ? dec : '0;
      if (wr_rise) wr_data <= din_s;
      bus_dout <= rd_lvl ? rsel : '0;
      bus_oe   <= rd_lvl;
      xcvr_dis <= ~rd_lvl;
    end
  end

endmodule

// File: rtl/hbus_front_chk.sv
module hbus_front_chk #(
  parameter int NREG = 8,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] wr_en,
  input logic [NREG-1:0] rd_pulse,
  input logic [DW-1:0]   bus_dout,
  input logic            bus_oe,
  input logic            xcvr_dis
);

  // R4
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_en));

  // R5
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |=> (wr_en == '0));

  // R6
  dout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_dout == '0));

  // R7
  dis_vs_oe_chk: assert property (@(posedge clk) disable iff (rst) xcvr_dis == !bus_oe);

  // R8
  rd_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_pulse));

  // R8
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pulse != '0) |=> (rd_pulse == '0));

  // R8
  rd_with_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pulse != '0) |-> ($rose(bus_oe)));

endmodule

bind hbus_front hbus_front_chk #(.NREG(NREG), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_pulse(rd_pulse),
  .bus_dout(bus_dout), .bus_oe(bus_oe), .xcvr_dis(xcvr_dis)
);

// File: tb/hbus_front_tb_top.sv
module hbus_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NREG = 1 << AW;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic cs_a = 1'b1, cs_b = 1'b1, cs_c_n = 1'b0, astb_n = 1'b0;
  logic rd_p = 1'b0, rd_n = 1'b1, wr_p = 1'b0, wr_n = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic [NREG*DW-1:0] reg_rdata;
  logic [NREG-1:0] wr_en, rd_pulse;
  logic [DW-1:0] wr_data, bus_dout;
  logic bus_oe, xcvr_dis;

  int vecs = 0;
  int miss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] rv(input int k);
    return 8'hA5 ^ (8'(k) * 8'h11);
  endfunction

  initial begin
    for (int k = 0; k < NREG; k++) reg_rdata[k*DW +: DW] = rv(k);
  end

  hbus_front #(.AW(AW), .DW(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .cs_a(cs_a), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .astb_n(astb_n), .rd_p(rd_p), .rd_n(rd_n), .wr_p(wr_p),
    .wr_n(wr_n), .bus_din(bus_din), .reg_rdata(reg_rdata), .wr_en(wr_en),
    .wr_data(wr_data), .rd_pulse(rd_pulse), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .xcvr_dis(xcvr_dis)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    check("R9 wr_en", 32'(wr_en), 0);
    check("R9 rd_pulse", 32'(rd_pulse), 0);
    check("R9 bus_oe", 32'(bus_oe), 0);
    check("R9 bus_dout", 32'(bus_dout), 0);
    check("R9 wr_data", 32'(wr_data), 0);
    check("R9 xcvr_dis", 32'(xcvr_dis), 1);
  endtask

  task automatic t_write_hi;
    reg_addr = 3'd3; bus_din = 8'h5A; wr_p = 1'b1;
    step(LAT);
    check("R4 wr_p enable", 32'(wr_en), 32'h08);
    check("R4 wr_data", 32'(wr_data), 32'h5A);
    for (int i = 0; i < 5; i++) begin
      step(1);
      check("R5 long strobe", 32'(wr_en), 0);
    end
    wr_p = 1'b0;
    step(4);
    check("R5 after release", 32'(wr_en), 0);
  endtask

  task automatic t_write_lo;
    reg_addr = 3'd6; bus_din = 8'hC3; wr_n = 1'b0;
    step(LAT);
    check("R4 wr_n enable", 32'(wr_en), 32'h40);
    check("R4 wr_n data", 32'(wr_data), 32'hC3);
    step(1);
    check("R5 wr_n single", 32'(wr_en), 0);
    wr_n = 1'b1;
    step(4);
  endtask

  task automatic t_nosel;
    for (int c = 0; c < 3; c++) begin
      cs_a = (c != 0); cs_b = (c != 1); cs_c_n = (c == 2);
      reg_addr = 3'd1; wr_p = 1'b1; rd_n = 1'b0;
      step(LAT);
      check("R1 no write", 32'(wr_en), 0);
      check("R1 no oe", 32'(bus_oe), 0);
      check("R1 no rd pulse", 32'(rd_pulse), 0);
      step(1);
      check("R1 no write later", 32'(wr_en), 0);
      wr_p = 1'b0; rd_n = 1'b1;
      cs_a = 1'b1; cs_b = 1'b1; cs_c_n = 1'b0;
      step(4);
    end
  endtask

  task automatic t_transparent;
    astb_n = 1'b0; reg_addr = 3'd2;
    step(2);
    reg_addr = 3'd5;
    step(2);
    wr_p = 1'b1;
    step(LAT);
    check("R2 live address", 32'(wr_en), 32'h20);
    wr_p = 1'b0;
    step(4);
  endtask

  task automatic t_freeze;
    astb_n = 1'b0; reg_addr = 3'd2;
    step(2);
    astb_n = 1'b1;
    step(2);
    reg_addr = 3'd7; cs_a = 1'b0;
    step(2);
    wr_p = 1'b1;
    step(LAT);
    check("R3 frozen address", 32'(wr_en), 32'h04);
    wr_p = 1'b0;
    step(4);
    // frozen deselect
    astb_n = 1'b0;
    step(2);
    astb_n = 1'b1;
    step(2);
    cs_a = 1'b1; reg_addr = 3'd0;
    step(2);
    wr_n = 1'b0;
    step(LAT);
    check("R3 frozen deselect", 32'(wr_en), 0);
    wr_n = 1'b1;
    step(4);
    astb_n = 1'b0;
    step(2);
    wr_p = 1'b1;
    step(LAT);
    check("R3 strobe low again", 32'(wr_en), 32'h01);
    wr_p = 1'b0;
    step(4);
  endtask

  task automatic t_read(input int k, input logic use_hi);
    reg_addr = AW'(k);
    if (use_hi) rd_p = 1'b1; else rd_n = 1'b0;
    step(LAT);
    check("R6 oe on", 32'(bus_oe), 1);
    check("R6 data", 32'(bus_dout), 32'(rv(k)));
    check("R7 dis low", 32'(xcvr_dis), 0);
    check("R8 rd pulse", 32'(rd_pulse), 32'(1 << k));
    step(1);
    check("R8 pulse single", 32'(rd_pulse), 0);
    check("R6 oe held", 32'(bus_oe), 1);
    rd_p = 1'b0; rd_n = 1'b1;
    step(LAT);
    check("R6 oe off", 32'(bus_oe), 0);
    check("R6 data zero", 32'(bus_dout), 0);
    check("R7 dis high", 32'(xcvr_dis), 1);
    step(2);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    t_reset();
    t_write_hi();
    t_write_lo();
    t_nosel();
    t_transparent();
    t_freeze();
    t_read(4, 1'b1);
    t_read(0, 1'b0);
    t_read(7, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    vecs++; miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule